// File: doc/BRIEF.md
# Super-Page Read Bypass and Write Combining Queue

This block sits between a host request stream and a flash operation sequencer. It tracks outstanding work at super-page granularity, not per request. A host read whose super-page already has an open read waiting or in flight is attached to that operation, so it adds no flash traffic. A host write whose super-page already has an open write that has not yet been issued is folded into that entry, and its chunk mask grows. The last super-page read that completed is remembered, so a later read to the same super-page finishes one cycle after acceptance and never reaches flash.

The target access pattern is a short read aligned to the start of a region, followed at once by a long read of the rest of that region. That pattern produces one flash operation instead of two. Data buffers are outside the block: each requester is identified by a tag, and completion is reported as a mask of tags.

Ordering is kept by an open flag on each entry. When a new entry is allocated for a super-page, every older entry for that super-page is closed to further merging. A read that arrives behind a queued write to its super-page is held back until nothing is in flight. Operations issue in arrival order, and the sequencer returns completions in issue order.

Top module: `sp_merge_queue`

## Requirements
- R1: A read whose super-page matches an open read entry (waiting or in flight) is merged into it. No further flash operation is issued, and both tags are reported done in the cycle that operation completes.
- R2: After a read of a super-page completes, a read to the same super-page raises its tag on `done_o` in the cycle after acceptance, and no flash operation is issued.
- R3: A write whose super-page matches an open write that has not yet been issued is merged into it, and the issued mask is the OR of the chunk spans. Bit k of the mask covers bytes [k*CHUNK_BYTES, (k+1)*CHUNK_BYTES) of the super-page. A write to a super-page whose write has already been issued gets a new entry.
- R4: An accepted write to the remembered super-page invalidates the last-read memory, so a later read to that super-page is not answered from it.
- R5: A read accepted while a write to its super-page is queued is not issued before that write has completed.
- R6: While DEPTH entries are held, `req_ready_o` is low and no request is taken, including one that could merge.
- R7: Operations issue in arrival order. On `cmp_valid_i` the oldest issued operation retires, and `done_o` carries exactly the tags attached to it.
- R8: Reads issue with an all-ones mask (the whole super-page). While `iss_valid_o` is high and `iss_ready_i` is low, the offered page and kind stay the same.
- R9: After reset `req_ready_o` is high, and `iss_valid_o` and `done_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Host request taken when high together with valid |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | ADDR_W | Byte address |
| req_len_i | input | log2(SP_BYTES)+1 | Length in bytes, 1 up to SP_BYTES |
| req_tag_i | input | log2(NUM_TAGS) | Requester tag |
| iss_valid_o | output | 1 | Flash operation offered |
| iss_ready_i | input | 1 | Sequencer takes the offered operation |
| iss_write_o | output | 1 | Offered operation is a program |
| iss_page_o | output | ADDR_W-log2(SP_BYTES) | Super-page number |
| iss_mask_o | output | SP_BYTES/CHUNK_BYTES | Chunk mask of the operation |
| cmp_valid_i | input | 1 | Oldest issued operation has completed |
| done_o | output | NUM_TAGS | Tags finished this cycle |

## Verification
The assertions rely on four things from the environment: a request lies within one super-page and has a nonzero length, tags are unique among outstanding requests, `cmp_valid_i` is raised only while an operation is in flight, and DEPTH and the chunk count are powers of two. The stimulus keeps to all of these. Every request stays inside its 64 KB super-page, tags are reused only after their done pulse, and completions are driven only after a matching issue handshake. Cache-hit reads are never placed in a completion cycle, so each `done_o` sample has a single source.

// File: rtl/sp_merge_pkg.sv
package sp_merge_pkg;
  typedef enum logic {OP_RD = 1'b0, OP_WR = 1'b1} op_e;
endpackage

// File: rtl/sp_span_mask.sv
module sp_span_mask #(
  parameter int SP_LOG2 = 16,
  parameter int CH_LOG2 = 13,
  localparam int NCH  = 1 << (SP_LOG2 - CH_LOG2),
  localparam int CI_W = SP_LOG2 - CH_LOG2
) (
  input  logic [SP_LOG2-1:0] off_i,
  input  logic [SP_LOG2:0]   len_i,
  output logic [NCH-1:0]     mask_o
);
  logic [SP_LOG2:0] end_off;
  logic [CI_W-1:0]  first_c, last_c;
  logic [NCH-1:0]   lo_m, hi_m;

  assign end_off = {1'b0, off_i} + len_i - 1'b1;
  assign first_c = off_i[SP_LOG2-1:CH_LOG2];
  // clip a span that runs past the super-page end
  assign last_c  = end_off[SP_LOG2] ? {CI_W{1'b1}} : end_off[SP_LOG2-1:CH_LOG2];
  assign lo_m    = {NCH{1'b1}} << first_c;
  assign hi_m    = {NCH{1'b1}} >> (CI_W'(NCH - 1) - last_c);
  assign mask_o  = lo_m & hi_m;
endmodule

// File: rtl/sp_merge_match.sv
module sp_merge_match #(
  parameter int DEPTH  = 4,
  parameter int PAGE_W = 16
) (
  input  logic [DEPTH-1:0]             e_valid_i,
  input  logic [DEPTH-1:0]             e_wr_i,
  input  logic [DEPTH-1:0]             e_open_i,
  input  logic [DEPTH-1:0]             e_lock_i,
  input  logic [DEPTH-1:0][PAGE_W-1:0] e_page_i,
  input  logic [PAGE_W-1:0]            req_page_i,
  input  logic                         req_wr_i,
  output logic [DEPTH-1:0]             merge_o,
  output logic [DEPTH-1:0]             same_o,
  output logic                         wr_conf_o
);
  logic [DEPTH-1:0] wr_same;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    assign same_o[gi]  = e_valid_i[gi] && (e_page_i[gi] == req_page_i);
    assign merge_o[gi] = same_o[gi] && e_open_i[gi] && !e_lock_i[gi] &&
                         (e_wr_i[gi] == req_wr_i);
    assign wr_same[gi] = same_o[gi] && e_wr_i[gi];
  end

  assign wr_conf_o = |wr_same;
endmodule

// File: rtl/sp_last_read.sv
module sp_last_read #(
  parameter int PAGE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_i,
  input  logic [PAGE_W-1:0] fill_page_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] wr_page_i,
  input  logic [PAGE_W-1:0] look_page_i,
  output logic              hit_o
);
  logic              vld_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      page_q <= '0;
    end else if (fill_i && !(wr_i && wr_page_i == fill_page_i)) begin
      vld_q  <= 1'b1;
      page_q <= fill_page_i;
    end else if (wr_i && wr_page_i == page_q) begin
      vld_q  <= 1'b0;
    end
  end

  assign hit_o = vld_q && (page_q == look_page_i);
endmodule

// File: rtl/sp_merge_queue.sv
module sp_merge_queue
  import sp_merge_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SP_BYTES    = 65536,
  parameter int CHUNK_BYTES = 8192,
  parameter int DEPTH       = 4,
  parameter int NUM_TAGS    = 8
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  req_valid_i,
  output logic                                  req_ready_o,
  input  logic                                  req_write_i,
  input  logic [ADDR_W-1:0]                     req_addr_i,
  input  logic [$clog2(SP_BYTES):0]             req_len_i,
  input  logic [$clog2(NUM_TAGS)-1:0]           req_tag_i,
  output logic                                  iss_valid_o,
  input  logic                                  iss_ready_i,
  output logic                                  iss_write_o,
  output logic [ADDR_W-$clog2(SP_BYTES)-1:0]    iss_page_o,
  output logic [SP_BYTES/CHUNK_BYTES-1:0]       iss_mask_o,
  input  logic                                  cmp_valid_i,
  output logic [NUM_TAGS-1:0]                   done_o
);
  localparam int SP_LOG2 = $clog2(SP_BYTES);
  localparam int CH_LOG2 = $clog2(CHUNK_BYTES);
  localparam int NCH     = SP_BYTES / CHUNK_BYTES;
  localparam int PAGE_W  = ADDR_W - SP_LOG2;
  localparam int PTR_W   = $clog2(DEPTH);
  localparam int CNT_W   = $clog2(DEPTH + 1);

  op_e                          e_op [DEPTH];
  logic [DEPTH-1:0]             e_valid, e_open, e_wait, e_wr, e_issued, e_lock;
  logic [DEPTH-1:0][PAGE_W-1:0] e_page;
  logic [DEPTH-1:0][NCH-1:0]    e_mask;
  logic [DEPTH-1:0][NUM_TAGS-1:0] e_tags;
  logic [PTR_W-1:0]             head_q, tail_q, iss_idx;
  logic [CNT_W-1:0]             cnt_q, nis_q;
  logic [NUM_TAGS-1:0]          hit_q, tag_bit;

  logic [PAGE_W-1:0] req_page;
  logic [NCH-1:0]    span;
  logic [DEPTH-1:0]  merge_vec, same_vec;
  logic              wr_conf, acc, iss_fire, cache_hit, rd_hit, do_merge, alloc, fill;

  assign req_page  = req_addr_i[ADDR_W-1:SP_LOG2];
  assign tag_bit   = NUM_TAGS'(1) << req_tag_i;
  assign iss_idx   = head_q + PTR_W'(nis_q);
  assign iss_fire  = iss_valid_o && iss_ready_i;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      e_wr[i]     = (e_op[i] == OP_WR);
      e_issued[i] = ({1'b0, PTR_W'(PTR_W'(i) - head_q)} < nis_q);
      // an entry about to retire, or a write already sent, takes no merge
      e_lock[i]   = (cmp_valid_i && PTR_W'(i) == head_q) ||
                    (e_wr[i] && (e_issued[i] || (iss_fire && PTR_W'(i) == iss_idx)));
    end
  end

  sp_span_mask #(.SP_LOG2(SP_LOG2), .CH_LOG2(CH_LOG2)) u_span (
    .off_i  (req_addr_i[SP_LOG2-1:0]),
    .len_i  (req_len_i),
    .mask_o (span)
  );

  sp_merge_match #(.DEPTH(DEPTH), .PAGE_W(PAGE_W)) u_match (
    .e_valid_i  (e_valid),
    .e_wr_i     (e_wr),
    .e_open_i   (e_open),
    .e_lock_i   (e_lock),
    .e_page_i   (e_page),
    .req_page_i (req_page),
    .req_wr_i   (req_write_i),
    .merge_o    (merge_vec),
    .same_o     (same_vec),
    .wr_conf_o  (wr_conf)
  );

  assign fill = cmp_valid_i && !e_wr[head_q] && e_open[head_q];

  sp_last_read #(.PAGE_W(PAGE_W)) u_last (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fill_i      (fill),
    .fill_page_i (e_page[head_q]),
    .wr_i        (acc && req_write_i),
    .wr_page_i   (req_page),
    .look_page_i (req_page),
    .hit_o       (cache_hit)
  );

  assign req_ready_o = (cnt_q != CNT_W'(DEPTH));
  assign acc         = req_valid_i && req_ready_o;
  assign rd_hit      = cache_hit && !req_write_i;
  assign do_merge    = !rd_hit && (|merge_vec);
  assign alloc       = acc && !rd_hit && !do_merge;

  // a read held behind a write leaves only with nothing in flight
  assign iss_valid_o = (cnt_q > nis_q) && (!e_wait[iss_idx] || nis_q == '0);
  assign iss_write_o = e_wr[iss_idx];
  assign iss_page_o  = e_page[iss_idx];
  assign iss_mask_o  = e_mask[iss_idx];
  assign done_o      = hit_q | (cmp_valid_i ? e_tags[head_q] : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_valid <= '0;
      e_open  <= '0;
      e_wait  <= '0;
      e_page  <= '0;
      e_mask  <= '0;
      e_tags  <= '0;
      for (int i = 0; i < DEPTH; i++) e_op[i] <= OP_RD;
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
      nis_q   <= '0;
      hit_q   <= '0;
    end else begin
      hit_q <= (acc && rd_hit) ? tag_bit : '0;
      if (cmp_valid_i) e_valid[head_q] <= 1'b0;
      if (acc && do_merge) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (merge_vec[i]) begin
            e_tags[i] <= e_tags[i] | tag_bit;
            if (req_write_i) e_mask[i] <= e_mask[i] | span;
          end
        end
      end
      if (alloc) begin
        for (int i = 0; i < DEPTH; i++) if (same_vec[i]) e_open[i] <= 1'b0;
        e_valid[tail_q] <= 1'b1;
        e_open[tail_q]  <= 1'b1;
        e_op[tail_q]    <= req_write_i ? OP_WR : OP_RD;
        e_wait[tail_q]  <= !req_write_i && wr_conf;
        e_page[tail_q]  <= req_page;
        e_mask[tail_q]  <= req_write_i ? span : {NCH{1'b1}};
        e_tags[tail_q]  <= tag_bit;
        tail_q          <= tail_q + 1'b1;
      end
      if (cmp_valid_i) head_q <= head_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(alloc) - CNT_W'(cmp_valid_i);
      nis_q <= nis_q + CNT_W'(iss_fire) - CNT_W'(cmp_valid_i);
    end
  end

  // R1
  merge_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(merge_vec));
  // R3
  span_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |-> span != '0);
  // R4
  cache_fresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && rd_hit) |-> !wr_conf);
  // R6
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(DEPTH) && !cmp_valid_i) |=> cnt_q == CNT_W'(DEPTH));
  // R7
  cmp_inflight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i |-> nis_q != '0);
  // R7
  done_on_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i |-> done_o != '0);
  // R8
  iss_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && !iss_ready_i) |=>
      (iss_valid_o && $stable(iss_page_o) && $stable(iss_write_o)));
  // R8
  rd_full_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && !iss_write_o) |-> &iss_mask_o);
endmodule

// File: tb/sp_merge_queue_tb.sv
module sp_merge_queue_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_ready_o, req_write_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [16:0] req_len_i = '0;
  logic [2:0]  req_tag_i = '0;
  logic        iss_valid_o, iss_ready_i = 1'b0, iss_write_o;
  logic [15:0] iss_page_o;
  logic [7:0]  iss_mask_o;
  logic        cmp_valid_i = 1'b0;
  logic [7:0]  done_o;
  int          checks = 0, fails = 0;

  always #5 clk_i = ~clk_i;

  sp_merge_queue u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_write_i, .req_addr_i,
    .req_len_i, .req_tag_i, .iss_valid_o, .iss_ready_i, .iss_write_o,
    .iss_page_o, .iss_mask_o, .cmp_valid_i, .done_o
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [16:0] len;
    logic [15:0] page;
    logic [7:0]  mask;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_0000, 17'h02000, 16'd0,  8'h01},
    '{32'h0001_2000, 17'h0E000, 16'd1,  8'hFE},
    '{32'h0003_4100, 17'h00001, 16'd3,  8'h04},
    '{32'h0005_1FFF, 17'h00002, 16'd5,  8'h03},
    '{32'h000A_0000, 17'h10000, 16'd10, 8'hFF},
    '{32'h0007_C000, 17'h04000, 16'd7,  8'hC0}
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic send(input bit w, input logic [31:0] a, input logic [16:0] l, input int tag);
    req_valid_i = 1'b1; req_write_i = w; req_addr_i = a; req_len_i = l;
    req_tag_i = 3'(tag);
    while (!req_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic issue(input string r, input bit w, input logic [15:0] pg, input logic [7:0] m);
    chk({r, " iss_valid"}, 32'(iss_valid_o), 32'd1);
    chk({r, " iss_write"}, 32'(iss_write_o), 32'(w));
    chk({r, " iss_page"},  32'(iss_page_o),  32'(pg));
    chk({r, " iss_mask"},  32'(iss_mask_o),  32'(m));
    iss_ready_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    iss_ready_i = 1'b0;
  endtask

  task automatic complete(input string r, input logic [7:0] exp);
    cmp_valid_i = 1'b1;
    #1;
    chk({r, " done"}, 32'(done_o), 32'(exp));
    @(posedge clk_i);
    @(negedge clk_i);
    cmp_valid_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9 reset state
    chk("R9 ready", 32'(req_ready_o), 32'd1);
    chk("R9 iss_valid", 32'(iss_valid_o), 32'd0);
    chk("R9 done", 32'(done_o), 32'd0);

    // R3 chunk span encoding, one write per vector
    for (int i = 0; i < 6; i++) begin
      send(1'b1, VECS[i].addr, VECS[i].len, i);
      issue("R3 span", 1'b1, VECS[i].page, VECS[i].mask);
      complete("R7 span", 8'(1 << i));
    end

    // R1 read merged into an in-flight read
    send(1'b0, 32'h0002_0000, 17'h02000, 0);
    issue("R8 read", 1'b0, 16'd2, 8'hFF);
    send(1'b0, 32'h0002_2000, 17'h0E000, 1);
    chk("R1 no second issue", 32'(iss_valid_o), 32'd0);
    complete("R1 shared", 8'h03);

    // R2 last-read hit
    send(1'b0, 32'h0002_4000, 17'h00100, 2);
    chk("R2 hit done", 32'(done_o), 32'h04);
    chk("R2 no issue", 32'(iss_valid_o), 32'd0);
    @(negedge clk_i);
    chk("R2 done pulse", 32'(done_o), 32'd0);

    // R4 write invalidates, R5 read waits for the write
    send(1'b1, 32'h0002_0000, 17'h02000, 3);
    send(1'b0, 32'h0002_0000, 17'h02000, 4);
    chk("R4 no hit", 32'(done_o), 32'd0);
    issue("R5 write first", 1'b1, 16'd2, 8'h01);
    chk("R5 read held", 32'(iss_valid_o), 32'd0);
    complete("R5 write done", 8'h08);
    issue("R5 read after", 1'b0, 16'd2, 8'hFF);
    complete("R5 read done", 8'h10);

    // R3 write combining before issue
    send(1'b1, 32'h0004_0000, 17'h02000, 0);
    send(1'b1, 32'h0004_2000, 17'h0E000, 1);
    issue("R3 merged", 1'b1, 16'd4, 8'hFF);
    chk("R3 single issue", 32'(iss_valid_o), 32'd0);
    complete("R3 merged", 8'h03);

    // R3 no merge into an issued write
    send(1'b1, 32'h0006_0000, 17'h02000, 0);
    issue("R3 first", 1'b1, 16'd6, 8'h01);
    send(1'b1, 32'h0006_4000, 17'h02000, 1);
    issue("R3 second", 1'b1, 16'd6, 8'h04);
    complete("R3 first", 8'h01);
    complete("R3 second", 8'h02);

    // R6 full queue
    for (int i = 0; i < 4; i++) send(1'b0, 32'(10 + i) << 16, 17'h02000, i);
    chk("R6 ready low", 32'(req_ready_o), 32'd0);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = 32'h000A_0000;
    req_len_i = 17'h02000; req_tag_i = 3'd5;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R6 still full", 32'(req_ready_o), 32'd0);
    for (int i = 0; i < 4; i++) issue("R7 order", 1'b0, 16'(10 + i), 8'hFF);
    for (int i = 0; i < 4; i++) complete("R6 R7 retire", 8'(1 << i));
    chk("R6 ready back", 32'(req_ready_o), 32'd1);

    // R7 merged entries retire in issue order
    send(1'b0, 32'h0014_0000, 17'h02000, 0);
    send(1'b0, 32'h0015_0000, 17'h02000, 1);
    send(1'b0, 32'h0014_2000, 17'h02000, 2);
    issue("R7 first", 1'b0, 16'd20, 8'hFF);
    issue("R7 second", 1'b0, 16'd21, 8'hFF);
    complete("R7 first", 8'h05);
    complete("R7 second", 8'h02);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule